// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a fast core clock. Software supplies an 11-bit divider setting that holds the division ratio minus two, so a setting of zero divides by two and the largest setting, 0x7FF, divides by 2049. The block produces the card clock level. It also produces two single-cycle strobes, one for each rising and one for each falling card clock edge, which the command and data engines use to shift bits in step with the card.

The full setting is used in identification mode. In data mode only the three low bits of the setting apply, which gives ratios from 2 to 9. A slow-card input overrides that limit and keeps the full setting in every mode. With a 250 MHz core clock, a setting of 623 gives about 400 kHz, and data-mode settings 0 to 7 give 125 MHz down to 27.8 MHz. The clock never stops: the slowest output is the largest setting.

A changed setting or mode is sampled only at a rising card clock edge, which starts a new period. The period in progress therefore always runs to completion and no shortened pulse reaches the card.

Top module: `sd_clk_divider`

## Requirements
- R1: While reset is asserted, sd_clk, rise_tick and fall_tick are all 0.
- R2: In identification mode (data_mode=0) the card clock period is div_val+2 core cycles.
- R3: In data mode (data_mode=1, slow_card=0) only div_val[2:0] takes effect, so the period is div_val[2:0]+2 core cycles and the upper bits have no effect.
- R4: When slow_card=1 the full div_val applies in data mode as well, so the period is div_val+2.
- R5: For a ratio N the high phase lasts ceil(N/2) core cycles and the low phase lasts floor(N/2), so an odd ratio gives the high phase the extra cycle.
- R6: rise_tick is 1 for exactly the first core cycle in which sd_clk is high, and fall_tick is 1 for exactly the first core cycle in which sd_clk is low after a high phase. The two strobes are never high together.
- R7: div_val, data_mode and slow_card are sampled only at the core clock edge that raises sd_clk. A change made within a period does not alter that period and applies from the next rising edge.
- R8: The largest setting, 0x7FF, gives a period of 2049 core cycles (1025 high, 1024 low), and the clock keeps toggling.
- R9: After reset is released, sd_clk rises at the first core clock edge, and that edge samples the setting for the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | 11 | Divider setting, ratio minus two |
| data_mode | input | 1 | 1 selects data mode, which uses only the three low bits |
| slow_card | input | 1 | 1 forces the full setting in every mode |
| sd_clk | output | 1 | Card clock level |
| rise_tick | output | 1 | One-cycle strobe on each rising card clock edge |
| fall_tick | output | 1 | One-cycle strobe on each falling card clock edge |

## Verification
The hardest case to bring about is a setting change in the middle of a period, since the effect must be held back until the next rising edge. The stimulus waits for a rising strobe, changes the setting partway through the high phase, and then measures both the period in progress and the one that follows. Settings that differ only in their upper bits, applied in data mode with and without the slow-card override, show whether those bits are masked or passed through. A reference model runs every cycle and compares each output on every clock.

// File: rtl/sd_clk_divider.sv
module sd_clk_divider #(
  parameter int DIV_W  = 11,
  parameter int FAST_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             data_mode,
  input  logic             slow_card,
  output logic             sd_clk,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int RW = DIV_W + 1;

  logic [DIV_W-1:0] sel_div, lat;
  logic [RW-1:0]    ratio, hi_len, lo_len, cnt;
  logic             last;

  assign sel_div = (data_mode && !slow_card) ? DIV_W'(div_val[FAST_W-1:0]) : div_val;
  assign ratio   = RW'(lat) + RW'(2);
  assign hi_len  = (ratio + RW'(1)) >> 1;
  assign lo_len  = ratio >> 1;
  assign last    = cnt == ((sd_clk ? hi_len : lo_len) - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_clk    <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      cnt       <= '0;
      lat       <= '0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (last) begin
        cnt    <= '0;
        sd_clk <= !sd_clk;
        if (!sd_clk) begin
          lat       <= sel_div;
          rise_tick <= 1'b1;
        end else begin
          fall_tick <= 1'b1;
        end
      end else begin
        cnt <= cnt + RW'(1);
      end
    end
  end

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (sd_clk && !$past(sd_clk)));
  p_fall_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!sd_clk && $past(sd_clk)));
  p_rose_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> rise_tick);
  p_tick_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));
  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat != $past(lat)) |-> rise_tick);
  p_phase_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_clk ? (cnt < hi_len) : (cnt < lo_len));
endmodule

// File: tb/tb_sd_clk_divider.sv
module tb_sd_clk_divider;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] div_val = '0;
  logic        data_mode = 1'b0;
  logic        slow_card = 1'b0;
  logic        sd_clk, rise_tick, fall_tick;

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";

  sd_clk_divider dut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .data_mode(data_mode),
    .slow_card(slow_card), .sd_clk(sd_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  always #(PERIOD/2) clk = !clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: countdown of cycles left in the current phase.
  int m_rem, m_lo, n;
  bit m_lvl, m_rise, m_fall;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_rem = 1; m_lo = 1; m_rise = 0; m_fall = 0;
    end else begin
      m_rise = 0; m_fall = 0;
      m_rem = m_rem - 1;
      if (m_rem == 0) begin
        if (!m_lvl) begin
          n = ((data_mode && !slow_card) ? int'(div_val) % 8 : int'(div_val)) + 2;
          m_rem = (n + 1) / 2; m_lo = n / 2; m_lvl = 1; m_rise = 1;
        end else begin
          m_rem = m_lo; m_lvl = 0; m_fall = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " R6 level"}, int'(sd_clk), int'(m_lvl));
      chk({cur_req, " R6 rise_tick"}, int'(rise_tick), int'(m_rise));
      chk({cur_req, " R6 fall_tick"}, int'(fall_tick), int'(m_fall));
    end
  end

  task automatic wait_rise();
    do @(negedge clk); while (!rise_tick);
  endtask

  task automatic measure(input string req, input int exp_hi, input int exp_lo);
    int h, l;
    cur_req = req;
    wait_rise();
    wait_rise();
    h = 0; l = 0;
    do begin h++; @(negedge clk); end while (sd_clk);
    do begin l++; @(negedge clk); end while (!sd_clk);
    chk({req, " high"}, h, exp_hi);
    chk({req, " low"}, l, exp_lo);
  endtask

  initial begin
    #(PERIOD*190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    chk("R1 sd_clk", int'(sd_clk), 0);
    chk("R1 rise_tick", int'(rise_tick), 0);
    chk("R1 fall_tick", int'(fall_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 first rise", int'(sd_clk), 1);

    div_val = 11'd0;    measure("R2 div0", 1, 1);
    div_val = 11'd1;    measure("R5 div1", 2, 1);
    div_val = 11'd623;  measure("R2 div623", 313, 312);
    data_mode = 1'b1;
    div_val = 11'h7FB;  measure("R3 masked", 3, 2);
    div_val = 11'd7;    measure("R3 div7", 5, 4);
    slow_card = 1'b1;
    div_val = 11'h7FB;  measure("R4 override", 1023, 1022);
    data_mode = 1'b0; slow_card = 1'b0;
    div_val = 11'h7FF;  measure("R8 max", 1025, 1024);

    // R7: change the setting in the middle of a high phase
    cur_req = "R7";
    div_val = 11'd5;
    wait_rise();
    wait_rise();
    h = 1; @(negedge clk);
    div_val = 11'd0;
    while (sd_clk) begin h++; @(negedge clk); end
    l = 0;
    do begin l++; @(negedge clk); end while (!sd_clk);
    chk("R7 held high", h, 4);
    chk("R7 held low", l, 3);
    h = 0; l = 0;
    do begin h++; @(negedge clk); end while (sd_clk);
    do begin l++; @(negedge clk); end while (!sd_clk);
    chk("R7 next high", h, 1);
    chk("R7 next low", l, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule